// File: doc/BRIEF.md
# SDRAM Command Controller

This block connects a plain request port to one four-bank, 16-bit synchronous DRAM. After reset it waits for the memory to power up. It then closes every bank, runs two refresh cycles and writes the mode word. Only when that sequence has finished does it begin to accept requests.

Each accepted request becomes a short command sequence: open the row, then a single column read or write, then close the bank. Reads return a whole burst. The burst length, the wrap order and the CAS latency are set by parameters and written into the mode word. Writes always move one word, and a byte mask selects which bytes are written. A free-running timer requests an auto-refresh. That refresh waits for any access in progress to finish and for its bank to be closed.

Clock enable goes high when reset ends and stays high, so a read burst is never turned into a clock-suspend by a low clock enable.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset the first commands are, in order: precharge with `memAddr[10]`=1, auto-refresh, auto-refresh, then mode load. `reqReady` stays low until the mode load has been issued.
- R2: Commands are encoded on {`memSelN`,`memRowStrbN`,`memColStrbN`,`memWrEnN`} as follows: mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, no-op 0111. No other code is ever driven.
- R3: The mode word is on `memAddr` with `memBank`=0. Bits [2:0] hold log2 of the burst length (1,2,4,8 give 0..3). Bit 3 is 1 for interleaved order. Bits [6:4] hold the CAS latency. Bit 9 is 1, which selects single-word writes. All other bits are 0.
- R4: `reqAddr` is split as bank = [23:22], row = [21:9] and column = [8:0]. Activate drives the row and the bank. Read and write drive the column on `memAddr[8:0]` with `memAddr[10]`=0, and they go only to the bank that is currently open.
- R5: The minimum spacing in clocks is: activate to read/write at least T_RCD; precharge to the next activate or refresh at least T_RP; refresh to the next command at least T_RFC; mode load to the next command at least T_MRD.
- R6: A write drives the stored data on `memDataOut` with `memDataOe`=1 in the same cycle as the write command. In that cycle `memByteMask` equals `reqMask`: bit 0 is the low byte, bit 1 is the high byte, and 1 means the byte is not written. `memDataOe` is high in no other cycle.
- R7: Read data is captured CAS_LAT clocks after the memory samples the read command. `rdValid` is then high for exactly BURST_LEN consecutive cycles. The first `rdValid` is seen T_RCD+CAS_LAT+1 cycles after the accepting edge.
- R8: Burst words are returned in the order the mode word selects. Sequential order adds the beat number to the start column, interleaved order XORs it with the start column, and both stay inside the aligned burst block.
- R9: Every access ends with a precharge of its own bank, with `memAddr[10]`=0. An activate is issued only when no bank is open.
- R10: An auto-refresh is issued only while all banks are closed. The gap between refreshes never exceeds REF_INTERVAL plus the length of one access.
- R11: `memClkEn` is low during reset and high from then on, including every cycle of a read burst.
- R12: A request is taken only on an edge where `reqValid` and `reqReady` are both high, and an activate follows on the next cycle. `reqReady` is low while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken on this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read burst |
| reqAddr | input | 24 | {bank, row, column} |
| reqWdata | input | 16 | Write word |
| reqMask | input | 2 | Per-byte write mask, 1 = keep old byte |
| rdValid | output | 1 | Read beat valid |
| rdData | output | 16 | Read beat |
| memClkEn | output | 1 | Memory clock enable |
| memSelN | output | 1 | Chip select, active low |
| memRowStrbN | output | 1 | Row strobe, active low |
| memColStrbN | output | 1 | Column strobe, active low |
| memWrEnN | output | 1 | Write enable, active low |
| memBank | output | 2 | Bank address |
| memAddr | output | 13 | Row, column or mode word |
| memDataOut | output | 16 | Write data to memory |
| memDataOe | output | 1 | Drive enable for write data |
| memDataIn | input | 16 | Read data from memory |
| memByteMask | output | 2 | Byte mask to memory |

## Verification
The assertions assume that a requester holds `reqValid` and its fields steady until acceptance. They also assume the requester never expects a second request to overlap a read burst, and that `reqReady` is judged without regard to `reqValid`. The stimulus keeps to this: it raises a request only after the previous access has completed, holds it until it sees `reqReady` at a falling edge, and then drops it. The behavioural memory in the bench drives read words only in the slots the mode word implies. Addresses are drawn from a small pool of banks, rows and low columns, so reads overlap earlier masked writes and cross burst-wrap boundaries.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  // {select_n, row_strobe_n, col_strobe_n, write_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ASEL_HOLD,
    ASEL_ROW,
    ASEL_COL,
    ASEL_ALLBANK,
    ASEL_ONEBANK,
    ASEL_MODE
  } asel_e;

  typedef struct packed {
    logic  latchReq;
    logic  issueWr;
    logic  issueRd;
    asel_e addrSel;
  } ctl_t;

  function automatic int maxInt(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [12:0] modeWord(int casLat, int burstLen, bit interleave);
    logic [12:0] w;
    w = '0;
    case (burstLen)
      1:       w[2:0] = 3'd0;
      2:       w[2:0] = 3'd1;
      4:       w[2:0] = 3'd2;
      default: w[2:0] = 3'd3;
    endcase
    w[3]   = interleave;
    w[6:4] = 3'(casLat);
    w[9]   = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_cmd_pkg::*;
#(
  parameter int CAS_LAT      = 3,
  parameter int BURST_LEN    = 4,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 6,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 2,
  parameter int PWR_CYCLES   = 10000,
  parameter int REF_INTERVAL = 390
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  output logic reqReady,
  output cmd_e cmdQ,
  output ctl_t ctl,
  output logic clkEnQ
);

  localparam int WAIT_MAX = maxInt(maxInt(maxInt(PWR_CYCLES, CAS_LAT + BURST_LEN),
                                          maxInt(T_RFC, T_RCD)),
                                   maxInt(maxInt(T_RP, T_MRD), T_WR));
  localparam int CNT_W = $clog2(WAIT_MAX + 1);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);

  typedef enum logic [2:0] {
    ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_RW, ST_PRE
  } st_e;

  st_e              st, stN;
  logic [CNT_W-1:0] cnt, cntN;
  cmd_e             cmdN;
  logic             wrQ;
  logic [REF_W-1:0] refCnt;
  logic             refPend, refClr;
  logic             rowOpenQ;

  assign reqReady = (st == ST_IDLE) && (cnt == '0) && !refPend;

  always_comb begin
    stN    = st;
    cntN   = (cnt != '0) ? cnt - 1'b1 : cnt;
    cmdN   = CMD_NOP;
    ctl    = '{latchReq: 1'b0, issueWr: 1'b0, issueRd: 1'b0, addrSel: ASEL_HOLD};
    refClr = 1'b0;
    if (cnt == '0) begin
      case (st)
        ST_PWR: begin
          cmdN = CMD_PRE; ctl.addrSel = ASEL_ALLBANK;
          stN = ST_IREF1; cntN = CNT_W'(T_RP - 1);
        end
        ST_IREF1: begin
          cmdN = CMD_REF; stN = ST_IREF2; cntN = CNT_W'(T_RFC - 1);
        end
        ST_IREF2: begin
          cmdN = CMD_REF; stN = ST_IMRS; cntN = CNT_W'(T_RFC - 1);
        end
        ST_IMRS: begin
          cmdN = CMD_LMR; ctl.addrSel = ASEL_MODE;
          stN = ST_IDLE; cntN = CNT_W'(T_MRD - 1);
        end
        ST_IDLE: begin
          if (refPend) begin
            cmdN = CMD_REF; refClr = 1'b1; cntN = CNT_W'(T_RFC - 1);
          end else if (reqValid) begin
            cmdN = CMD_ACT; ctl.addrSel = ASEL_ROW; ctl.latchReq = 1'b1;
            stN = ST_RW; cntN = CNT_W'(T_RCD - 1);
          end
        end
        ST_RW: begin
          ctl.addrSel = ASEL_COL;
          stN = ST_PRE;
          if (wrQ) begin
            cmdN = CMD_WR; ctl.issueWr = 1'b1; cntN = CNT_W'(T_WR - 1);
          end else begin
            cmdN = CMD_RD; ctl.issueRd = 1'b1; cntN = CNT_W'(CAS_LAT + BURST_LEN - 1);
          end
        end
        ST_PRE: begin
          cmdN = CMD_PRE; ctl.addrSel = ASEL_ONEBANK;
          stN = ST_IDLE; cntN = CNT_W'(T_RP - 1);
        end
        default: stN = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_PWR;
      cnt    <= CNT_W'(PWR_CYCLES - 1);
      cmdQ   <= CMD_NOP;
      wrQ    <= 1'b0;
      clkEnQ <= 1'b0;
    end else begin
      st     <= stN;
      cnt    <= cntN;
      cmdQ   <= cmdN;
      clkEnQ <= 1'b1;
      if (ctl.latchReq) wrQ <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt  <= REF_W'(REF_INTERVAL - 1);
      refPend <= 1'b0;
    end else if (refCnt == '0) begin
      refCnt  <= REF_W'(REF_INTERVAL - 1);
      refPend <= 1'b1;
    end else begin
      refCnt <= refCnt - 1'b1;
      if (refClr) refPend <= 1'b0;
    end
  end

  // Open-row tracker built from the issued command stream, for checking.
  always_ff @(posedge clk) begin
    if (!rstN) rowOpenQ <= 1'b0;
    else if (cmdQ == CMD_ACT) rowOpenQ <= 1'b1;
    else if (cmdQ == CMD_PRE) rowOpenQ <= 1'b0;
  end

  // R9
  act_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_ACT) |-> !rowOpenQ);

  // R10
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_REF) |-> !rowOpenQ);

  // R4
  rw_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdQ == CMD_RD) || (cmdQ == CMD_WR)) |-> rowOpenQ);

  // R12
  accept_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (cmdQ == CMD_ACT));

endmodule

// File: rtl/sdram_io_dpath.sv
module sdram_io_dpath
  import sdram_cmd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctl_t                          ctl,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W/8-1:0]           reqMask,
  input  logic [DATA_W-1:0]             memDataIn,
  output logic [BANK_W-1:0]             memBank,
  output logic [ROW_W-1:0]              memAddr,
  output logic [DATA_W-1:0]             memDataOut,
  output logic                          memDataOe,
  output logic [DATA_W/8-1:0]           memByteMask,
  output logic                          rdValid,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdBusy
);

  localparam int AW     = BANK_W + ROW_W + COL_W;
  localparam int MASK_W = DATA_W / 8;
  localparam int SR_W   = CAS_LAT + BURST_LEN;
  localparam logic [SR_W-1:0] SR_LOAD = {{BURST_LEN{1'b1}}, {CAS_LAT{1'b0}}};
  localparam logic [ROW_W-1:0] MODE_VAL = ROW_W'(modeWord(CAS_LAT, BURST_LEN, INTERLEAVE));
  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1) << 10;

  logic [AW-1:0]     addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [MASK_W-1:0] maskQ;
  logic [SR_W-1:0]   capSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (ctl.latchReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memBank <= '0;
      memAddr <= '0;
    end else begin
      case (ctl.addrSel)
        ASEL_ROW: begin
          memBank <= reqAddr[AW-1 -: BANK_W];
          memAddr <= reqAddr[COL_W +: ROW_W];
        end
        ASEL_COL: begin
          memBank <= addrQ[AW-1 -: BANK_W];
          memAddr <= ROW_W'(addrQ[COL_W-1:0]);
        end
        ASEL_ALLBANK: begin
          memBank <= '0;
          memAddr <= ALL_BANKS;
        end
        ASEL_ONEBANK: begin
          memBank <= addrQ[AW-1 -: BANK_W];
          memAddr <= '0;
        end
        ASEL_MODE: begin
          memBank <= '0;
          memAddr <= MODE_VAL;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memDataOe   <= 1'b0;
      memDataOut  <= '0;
      memByteMask <= '0;
    end else begin
      memDataOe   <= ctl.issueWr;
      memByteMask <= ctl.issueWr ? maskQ : '0;
      if (ctl.issueWr) memDataOut <= wdataQ;
    end
  end

  // Capture slots: bit 0 marks the edge on which the memory word is taken.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capSr   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      capSr   <= ctl.issueRd ? SR_LOAD : (capSr >> 1);
      rdValid <= capSr[0];
      if (capSr[0]) rdData <= memDataIn;
    end
  end

  assign rdBusy = |capSr;

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 9,
  parameter int BANK_W       = 2,
  parameter int CAS_LAT      = 3,
  parameter int BURST_LEN    = 4,
  parameter bit INTERLEAVE   = 1'b1,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 6,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 2,
  parameter int PWR_CYCLES   = 10000,
  parameter int REF_INTERVAL = 390
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W/8-1:0]           reqMask,
  output logic                          rdValid,
  output logic [DATA_W-1:0]             rdData,
  output logic                          memClkEn,
  output logic                          memSelN,
  output logic                          memRowStrbN,
  output logic                          memColStrbN,
  output logic                          memWrEnN,
  output logic [BANK_W-1:0]             memBank,
  output logic [ROW_W-1:0]              memAddr,
  output logic [DATA_W-1:0]             memDataOut,
  output logic                          memDataOe,
  input  logic [DATA_W-1:0]             memDataIn,
  output logic [DATA_W/8-1:0]           memByteMask
);

  cmd_e cmdQ;
  ctl_t ctl;
  logic rdBusy;

  sdram_seq_fsm #(
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR(T_WR), .PWR_CYCLES(PWR_CYCLES),
    .REF_INTERVAL(REF_INTERVAL)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .cmdQ(cmdQ), .ctl(ctl), .clkEnQ(memClkEn)
  );

  sdram_io_dpath #(
    .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .INTERLEAVE(INTERLEAVE)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .memDataIn(memDataIn), .memBank(memBank), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memByteMask(memByteMask),
    .rdValid(rdValid), .rdData(rdData), .rdBusy(rdBusy)
  );

  assign {memSelN, memRowStrbN, memColStrbN, memWrEnN} = cmdQ;

  // R11
  burst_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdBusy |-> memClkEn);

  // R6
  oe_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> (cmdQ == CMD_WR));

endmodule

// File: tb/sdram_cmd_ctrl_env.sv
module sdram_cmd_ctrl_env #(
  parameter int          CL   = 3,
  parameter int          BL   = 4,
  parameter bit          ILV  = 1'b1,
  parameter int unsigned SEED = 1
) (
  input  logic clk,
  input  logic rstN,
  output int   nChk,
  output int   nFail,
  output logic done
);

  localparam int T_RCD = 2, T_RP = 2, T_RFC = 6, T_MRD = 2, T_WR = 2;
  localparam int PWR = 40, REFI = 90;
  localparam int REF_BOUND = REFI + T_RFC + T_RCD + T_WR + CL + BL + T_RP + 6;
  localparam logic [12:0] EXP_MODE = 13'((1 << 9) | (CL << 4) | (int'(ILV) << 3) | $clog2(BL));

  logic        reqValid, reqReady, reqWrite, rdValid;
  logic [23:0] reqAddr;
  logic [15:0] reqWdata, rdData, memDataOut, memDataIn;
  logic [1:0]  reqMask, memBank, memByteMask;
  logic [12:0] memAddr;
  logic        memClkEn, memSelN, memRowStrbN, memColStrbN, memWrEnN, memDataOe;

  sdram_cmd_ctrl #(
    .CAS_LAT(CL), .BURST_LEN(BL), .INTERLEAVE(ILV), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR(T_WR), .PWR_CYCLES(PWR), .REF_INTERVAL(REFI)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData), .memClkEn(memClkEn), .memSelN(memSelN),
    .memRowStrbN(memRowStrbN), .memColStrbN(memColStrbN), .memWrEnN(memWrEnN),
    .memBank(memBank), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn), .memByteMask(memByteMask)
  );

  logic [15:0] mem    [int unsigned];
  logic [15:0] shadow [int unsigned];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s (CL%0d BL%0d): actual %h expected %h", tag, CL, BL, act, exp);
    end
  endtask

  function automatic int unsigned mkKey(logic [1:0] b, logic [12:0] r, logic [8:0] c);
    return {8'h0, b, r, c};
  endfunction

  function automatic logic [15:0] initVal(int unsigned k);
    return 16'(k ^ (k >> 9)) ^ 16'hC3A5;
  endfunction

  function automatic logic [8:0] burstCol(logic [8:0] start, int i);
    logic [8:0] m;
    m = 9'(BL - 1);
    return (start & ~m) | ((ILV ? (start ^ 9'(i)) : (start + 9'(i))) & m);
  endfunction

  // ---------------- behavioural memory ----------------
  int          cyc, sinceAct, sincePre, sinceRef, sinceMrs, lastRef, initStep;
  bit          open, rdPend;
  logic [1:0]  openBank, rdBank;
  logic [12:0] openRow, rdRow;
  logic [8:0]  rdCol;
  int          rdDelay, rdIdx;

  always @(posedge clk) begin
    logic [15:0] dqNext, old;
    logic [3:0]  code;
    int unsigned k;
    if (!rstN) begin
      cyc = 0; sinceAct = 1000; sincePre = 1000; sinceRef = 1000; sinceMrs = 1000;
      lastRef = 0; initStep = 0; open = 0; rdPend = 0; rdDelay = 0; rdIdx = 0;
      memDataIn <= 16'hDEAD;
    end else begin
      cyc++; sinceAct++; sincePre++; sinceRef++; sinceMrs++;
      dqNext = 16'hDEAD;
      if (rdPend) begin
        if (rdDelay == 0) begin
          k = mkKey(rdBank, rdRow, burstCol(rdCol, rdIdx));
          dqNext = mem.exists(k) ? mem[k] : initVal(k);
          rdIdx++;
          if (rdIdx == BL) rdPend = 0;
        end else rdDelay--;
      end
      memDataIn <= dqNext;
      if (rdPend) chk(memClkEn, "R11 clock enable during burst", memClkEn, 1);
      code = {memSelN, memRowStrbN, memColStrbN, memWrEnN};
      if (!memSelN && code != 4'b0111) begin
        chk(memClkEn, "R11 clock enable with command", memClkEn, 1);
        if (initStep < 4) begin
          case (initStep)
            0: chk(code == 4'b0010 && memAddr[10], "R1 first precharge-all", {code, memAddr}, {4'b0010, 13'h400});
            1, 2: chk(code == 4'b0001, "R1 init refresh", code, 4'b0001);
            default: begin
              chk(code == 4'b0000, "R1 mode load last", code, 4'b0000);
              chk(memAddr == EXP_MODE && memBank == 0, "R3 mode word", memAddr, EXP_MODE);
            end
          endcase
          initStep++;
        end
        case (code)
          4'b0011: begin
            chk(!open, "R9 activate with bank open", open, 0);
            chk(sincePre >= T_RP && sinceRef >= T_RFC && sinceMrs >= T_MRD,
                "R5 gap before activate", {sincePre[15:0], sinceRef[15:0]}, {16'(T_RP), 16'(T_RFC)});
            open = 1; openBank = memBank; openRow = memAddr; sinceAct = 0;
          end
          4'b0100, 4'b0101: begin
            chk(open && memBank == openBank && !memAddr[10], "R4 column access target",
                {open, memBank, memAddr}, {1'b1, openBank, 13'h0});
            chk(sinceAct >= T_RCD, "R5 activate to column", sinceAct, T_RCD);
            if (code == 4'b0100) begin
              chk(memDataOe, "R6 data drive with write", memDataOe, 1);
              k = mkKey(openBank, openRow, memAddr[8:0]);
              old = mem.exists(k) ? mem[k] : initVal(k);
              mem[k] = {memByteMask[1] ? old[15:8] : memDataOut[15:8],
                        memByteMask[0] ? old[7:0]  : memDataOut[7:0]};
            end else begin
              rdPend = 1; rdDelay = CL - 2; rdIdx = 0;
              rdBank = openBank; rdRow = openRow; rdCol = memAddr[8:0];
            end
          end
          4'b0010: begin
            if (!memAddr[10]) begin
              chk(open && memBank == openBank, "R9 precharge of open bank", {open, memBank}, {1'b1, openBank});
              open = 0;
            end
            sincePre = 0;
          end
          4'b0001: begin
            chk(!open && sincePre >= T_RP && sinceRef >= T_RFC, "R10 refresh with banks closed",
                {open, sinceRef[15:0]}, {1'b0, 16'(T_RFC)});
            if (initStep == 4 && lastRef != 0)
              chk(cyc - lastRef <= REF_BOUND, "R10 refresh interval", cyc - lastRef, REF_BOUND);
            lastRef = cyc; sinceRef = 0;
          end
          4'b0000: sinceMrs = 0;
          default: chk(0, "R2 unknown command code", code, 4'b0111);
        endcase
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReq(input bit wr, input logic [23:0] a, input logic [15:0] d, input logic [1:0] m);
    int w;
    int unsigned k;
    logic [15:0] old, exp;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    chk(!reqReady, "R12 ready low during access", reqReady, 0);
    if (wr) begin
      k = mkKey(a[23:22], a[21:9], a[8:0]);
      old = shadow.exists(k) ? shadow[k] : initVal(k);
      shadow[k] = {m[1] ? old[15:8] : d[15:8], m[0] ? old[7:0] : d[7:0]};
    end else begin
      w = 0;
      while (!rdValid && w < 100) begin @(negedge clk); w++; end
      chk(w == T_RCD + CL + 1, "R7 read latency", w, T_RCD + CL + 1);
      for (int i = 0; i < BL; i++) begin
        k = mkKey(a[23:22], a[21:9], burstCol(a[8:0], i));
        exp = shadow.exists(k) ? shadow[k] : initVal(k);
        chk(rdValid && rdData == exp, "R8 burst word", {rdValid, rdData}, {1'b1, exp});
        @(negedge clk);
      end
      chk(!rdValid, "R7 burst length", rdValid, 0);
    end
  endtask

  initial begin
    int unsigned r;
    logic [23:0] a;
    logic [12:0] row;
    nChk = 0; nFail = 0; done = 0;
    reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0; reqMask = '0;
    r = $urandom(SEED);
    @(negedge clk);
    chk(!memClkEn, "R11 clock enable low in reset", memClkEn, 0);
    chk(!reqReady && !rdValid, "R12 idle outputs in reset", {reqReady, rdValid}, 0);
    while (!rstN) @(negedge clk);
    while (!reqReady) @(negedge clk);
    chk(initStep == 4, "R1 ready only after init", initStep, 4);
    // directed: byte masks on one word, then wrap-around reads
    a = {2'd1, 13'd5, 9'd3};
    doReq(1, a, 16'h1234, 2'b00);
    doReq(1, a, 16'hABCD, 2'b01);
    doReq(0, {2'd1, 13'd5, 9'd1}, 16'h0, 2'b00);
    doReq(1, a, 16'h9F70, 2'b10);
    doReq(1, a, 16'h5555, 2'b11);
    doReq(0, a, 16'h0, 2'b00);
    doReq(1, {2'd3, 13'h1FFF, 9'h1FF}, 16'hBEEF, 2'b00);
    doReq(0, {2'd3, 13'h1FFF, 9'h1FF}, 16'h0, 2'b00);
    doReq(0, {2'd3, 13'h1FFF, 9'(BL - 1)}, 16'h0, 2'b00);
    // random mix over a small pool
    for (int n = 0; n < 90; n++) begin
      r = $urandom();
      case (r[3:2])
        2'd0: row = 13'd0;
        2'd1: row = 13'd1;
        2'd2: row = 13'h1FFF;
        default: row = 13'($urandom());
      endcase
      a = {r[5:4], row, 5'd0, r[9:6]};
      doReq(r[0], a, 16'($urandom()), r[11:10]);
    end
    done = 1;
  end

endmodule

// File: tb/sdram_cmd_ctrl_tb_top.sv
module sdram_cmd_ctrl_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int   chkA, failA, chkB, failB;
  logic doneA, doneB;
  int   cycles = 0;
  int   wdFail = 0;

  always #10 clk = ~clk;

  sdram_cmd_ctrl_env #(.CL(3), .BL(4), .ILV(1'b1), .SEED(32'd17)) envA_i (
    .clk(clk), .rstN(rstN), .nChk(chkA), .nFail(failA), .done(doneA));

  sdram_cmd_ctrl_env #(.CL(2), .BL(8), .ILV(1'b0), .SEED(32'd91)) envB_i (
    .clk(clk), .rstN(rstN), .nChk(chkB), .nFail(failB), .done(doneB));

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
  end

  always @(posedge clk) cycles++;

  initial begin
    while (!(doneA === 1'b1 && doneB === 1'b1) && cycles < 150000) @(negedge clk);
    if (cycles >= 150000) begin
      wdFail = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             chkA + chkB + wdFail, failA + failB + wdFail);
    $finish;
  end

endmodule